// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block runs the start-loop instruction and the per-fetch loop test for a small signal-processing core that repeats a block of instructions without any branch instruction. It owns the loop end address, the remaining pass count, the loop-active flag and a hardware stack. Each stack entry is two 16-bit halves. A start command saves the outer loop's state on the stack over three cycles, so loops nest to the depth of the stack.

While a loop is active, the block compares every fetch address with the loop end address. When they match and passes remain, it redirects fetch to the first body instruction, which it reads from the top stack entry without removing it. On the final pass it restores the outer loop's state from the stack, drops two entries and lets fetch continue in sequence. It also presents the saved status word, so the core can restore its loop flag.

Top module: `hwLoopUnit`

## Requirements
- R1: After reset the loop flag, the redirect valid, the end-of-loop valid, the overflow flag, the loop end address and the loop count are all zero.
- R2: A start command is taken on one clock edge when no start sequence is running. On that edge the old {end address, count} pair is pushed, with the end address in the high half, and the new count is loaded. On the next edge {first body address, status word} is pushed, with the address in the high half, and the new end address is loaded. The loop flag reads 1 after the third edge.
- R3: With `startShort` high, the count takes `startCount[11:0]` and its upper 4 bits are cleared.
- R4: When the loop flag is 1, `fetchValid` is high, `fetchPc` equals the end address and the count is not 1, `pcOvrValid` is high in the same cycle and `pcOvr` is the high half of the top entry. The count decreases by one on the next edge and the stack is unchanged.
- R5: A count of 0 gives 65,536 passes through the loop end address.
- R6: When the same match occurs with a count of 1, `pcOvrValid` stays low. `srRestoreValid` is high with `srRestore` equal to the low half of the top entry. On the next edge the loop flag takes bit 15 of that half, the end address takes the high half of the entry below, the count takes the low half of the entry below, and two entries are dropped.
- R7: With the loop flag at 0, or with a fetch address other than the end address, neither `pcOvrValid` nor `srRestoreValid` is raised.
- R8: When an inner loop exits, the outer loop's end address, remaining count and loop flag are back in force, and the outer loop continues to its correct pass total.
- R9: The stack holds 15 entries. A push onto a full stack does not write and leaves the stack pointer unchanged. It sets `overflow`, which stays at 1 until reset.
- R10: The status word pushed by a start carries the block's loop flag at bit 15, in place of bit 15 of `srIn`.
- R11: During a start sequence, and in the cycle a start command is taken, fetches are ignored and raise neither valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start-loop command |
| startShort | input | 1 | Count is a 12-bit immediate |
| startCount | input | 16 | Pass count (0 means 65,536) |
| startEnd | input | 16 | Address of the last body instruction |
| startNextPc | input | 16 | Address of the first body instruction |
| srIn | input | 16 | Current status word |
| fetchValid | input | 1 | A fetch occurs this cycle |
| fetchPc | input | 16 | Address being fetched |
| pcOvrValid | output | 1 | Redirect fetch to pcOvr |
| pcOvr | output | 16 | First body address of the active loop |
| srRestoreValid | output | 1 | Loop exit; the core restores its status word |
| srRestore | output | 16 | Saved status word, loop flag at bit 15 |
| loopFlag | output | 1 | Loop active |
| loopAddr | output | 16 | Current loop end address |
| loopCount | output | 16 | Current remaining count |
| overflow | output | 1 | Sticky stack overflow |

## Verification
A wrong stack pointer or a swapped stack half shows up at the first exit of a nested loop. `loopAddr`, `loopCount` and `srRestore` then read wrong values in the cycle after the exit, and the outer loop redirects to a wrong address on its next pass. A wrong count shows up only as a wrong pass total, so the bench counts every pass of loops set to 1, 2, 3 and 65,536 passes. The bench also checks the single-cycle redirect address on each pass.

// File: rtl/hwLoopPkg.sv
package hwLoopPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH_PC, ST_ARM} seqState_t;

  typedef struct packed {
    logic capture;
    logic pushLaLc;
    logic pushPcSr;
    logic loadLa;
    logic setLf;
    logic loopBack;
    logic loopEnd;
  } loopStrobe_t;
endpackage

// File: rtl/hwLoopCtrl.sv
module hwLoopCtrl
  import hwLoopPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        fetchValid,
  input  logic        hit,
  input  logic        lcOne,
  output loopStrobe_t strobe
);
  seqState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (startValid) begin
          strobe.capture  = 1'b1;
          strobe.pushLaLc = 1'b1;
          stateNext       = ST_PUSH_PC;
        end else if (fetchValid && hit) begin
          if (lcOne) strobe.loopEnd  = 1'b1;
          else       strobe.loopBack = 1'b1;
        end
      end
      ST_PUSH_PC: begin
        strobe.pushPcSr = 1'b1;
        strobe.loadLa   = 1'b1;
        stateNext       = ST_ARM;
      end
      ST_ARM: begin
        strobe.setLf = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R11: at most one action per cycle
  a_r11_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loopBack, strobe.loopEnd, strobe.pushLaLc, strobe.pushPcSr, strobe.setLf}));

  // R2: the sequence always runs its three cycles
  a_r2_sequence_order: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushLaLc |=> strobe.pushPcSr);
endmodule

// File: rtl/hwLoopDatapath.sv
module hwLoopDatapath
  import hwLoopPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SHORT_W     = 12,
  parameter int STACK_DEPTH = 15,
  parameter int LF_BIT      = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  loopStrobe_t       strobe,
  input  logic              startShort,
  input  logic [DATA_W-1:0] startCount,
  input  logic [DATA_W-1:0] startEnd,
  input  logic [DATA_W-1:0] startNextPc,
  input  logic [DATA_W-1:0] srIn,
  input  logic [DATA_W-1:0] fetchPc,
  output logic              hit,
  output logic              lcOne,
  output logic [DATA_W-1:0] la,
  output logic [DATA_W-1:0] lc,
  output logic              lf,
  output logic [DATA_W-1:0] topHi,
  output logic [DATA_W-1:0] topLo,
  output logic              overflow
);
  localparam int ENTRY_W = 2 * DATA_W;
  localparam int SP_W    = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W   = $clog2(STACK_DEPTH);

  logic [ENTRY_W-1:0] stk [STACK_DEPTH];
  logic [SP_W-1:0]    sp;
  logic [DATA_W-1:0]  endQ, pcQ, srQ;
  logic [DATA_W-1:0]  lcLoad, srTagged;
  logic [ENTRY_W-1:0] pushWord, topEntry, belowEntry;
  logic [IDX_W-1:0]   wrIdx, topIdx, belowIdx;
  logic               doPush, full;

  always_comb begin
    lcLoad   = startShort ? DATA_W'(startCount[SHORT_W-1:0]) : startCount;
    srTagged = srQ;
    srTagged[LF_BIT] = lf;
    pushWord = strobe.pushLaLc ? {la, lc} : {pcQ, srTagged};
    doPush   = strobe.pushLaLc | strobe.pushPcSr;
    full     = (sp == SP_W'(STACK_DEPTH));
    wrIdx    = IDX_W'(sp);
    topIdx   = IDX_W'(sp - SP_W'(1));
    belowIdx = IDX_W'(sp - SP_W'(2));
    topEntry   = (sp >= SP_W'(1)) ? stk[topIdx]   : '0;
    belowEntry = (sp >= SP_W'(2)) ? stk[belowIdx] : '0;
    topHi    = topEntry[ENTRY_W-1:DATA_W];
    topLo    = topEntry[DATA_W-1:0];
    hit      = lf && (fetchPc == la);
    lcOne    = (lc == DATA_W'(1));
  end

  always_ff @(posedge clk) begin
    if (doPush && !full) stk[wrIdx] <= pushWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      la <= '0; lc <= '0; lf <= 1'b0; sp <= '0; overflow <= 1'b0;
      endQ <= '0; pcQ <= '0; srQ <= '0;
    end else begin
      if (strobe.capture) begin
        endQ <= startEnd;
        pcQ  <= startNextPc;
        srQ  <= srIn;
        lc   <= lcLoad;
      end
      if (doPush) begin
        if (full) overflow <= 1'b1;
        else      sp <= sp + SP_W'(1);
      end
      if (strobe.loadLa)   la <= endQ;
      if (strobe.setLf)    lf <= 1'b1;
      if (strobe.loopBack) lc <= lc - DATA_W'(1);
      if (strobe.loopEnd) begin
        lf <= topEntry[LF_BIT];
        la <= belowEntry[ENTRY_W-1:DATA_W];
        lc <= belowEntry[DATA_W-1:0];
        sp <= sp - SP_W'(2);
      end
    end
  end

  a_r4_count_steps_down: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loopBack |=> (lc == $past(lc) - DATA_W'(1)) && (sp == $past(sp)));

  a_r6_exit_drops_two: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loopEnd |=> sp == $past(sp) - SP_W'(2));

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  a_r9_full_push_holds: assert property (@(posedge clk) disable iff (!rstN)
    (doPush && full) |=> (sp == $past(sp)) && overflow);

  a_r2_flag_armed: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setLf |=> lf);
endmodule

// File: rtl/hwLoopUnit.sv
module hwLoopUnit
  import hwLoopPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SHORT_W     = 12,
  parameter int STACK_DEPTH = 15,
  parameter int LF_BIT      = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              startShort,
  input  logic [DATA_W-1:0] startCount,
  input  logic [DATA_W-1:0] startEnd,
  input  logic [DATA_W-1:0] startNextPc,
  input  logic [DATA_W-1:0] srIn,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] fetchPc,
  output logic              pcOvrValid,
  output logic [DATA_W-1:0] pcOvr,
  output logic              srRestoreValid,
  output logic [DATA_W-1:0] srRestore,
  output logic              loopFlag,
  output logic [DATA_W-1:0] loopAddr,
  output logic [DATA_W-1:0] loopCount,
  output logic              overflow
);
  loopStrobe_t strobe;
  logic        hit, lcOne;

  hwLoopCtrl uCtrl (
    .clk, .rstN, .startValid, .fetchValid, .hit, .lcOne, .strobe
  );

  hwLoopDatapath #(
    .DATA_W(DATA_W), .SHORT_W(SHORT_W), .STACK_DEPTH(STACK_DEPTH), .LF_BIT(LF_BIT)
  ) uDp (
    .clk, .rstN, .strobe, .startShort, .startCount, .startEnd, .startNextPc,
    .srIn, .fetchPc, .hit, .lcOne,
    .la(loopAddr), .lc(loopCount), .lf(loopFlag),
    .topHi(pcOvr), .topLo(srRestore), .overflow
  );

  assign pcOvrValid     = strobe.loopBack;
  assign srRestoreValid = strobe.loopEnd;

  // R7: no redirect or exit while the loop flag is clear
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !loopFlag |-> !(pcOvrValid || srRestoreValid));
endmodule

// File: tb/hwLoopUnit_test.sv
module hwLoopUnit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0, startShort = 1'b0;
  logic [15:0] startCount = '0, startEnd = '0, startNextPc = '0, srIn = '0;
  logic        fetchValid = 1'b0;
  logic [15:0] fetchPc = '0;
  logic        pcOvrValid, srRestoreValid, loopFlag, overflow;
  logic [15:0] pcOvr, srRestore, loopAddr, loopCount;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwLoopUnit uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic startLoop(bit sh, logic [15:0] cnt, logic [15:0] endA,
                           logic [15:0] nxt, logic [15:0] sr);
    logic [15:0] curLa;
    @(negedge clk);
    curLa = loopAddr;
    startValid = 1'b1; startShort = sh; startCount = cnt;
    startEnd = endA; startNextPc = nxt; srIn = sr;
    fetchValid = 1'b1; fetchPc = curLa;
    #1 chk("R11 start cycle fetch ignored", {pcOvrValid, srRestoreValid}, 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      startValid = 1'b0;
      #1 chk("R11 sequence fetch ignored", {pcOvrValid, srRestoreValid}, 0);
    end
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  task automatic fetchAt(logic [15:0] pc, bit expOv, logic [15:0] expPc, bit expEnd, string tag);
    @(negedge clk);
    fetchValid = 1'b1; fetchPc = pc;
    #1;
    chk(tag, {pcOvrValid, srRestoreValid}, {expOv, expEnd});
    if (expOv) chk(tag, pcOvr, expPc);
  endtask

  // Run a core model from firstPc until the loop exits; count end-address passes.
  task automatic runPasses(logic [15:0] firstPc, logic [15:0] endPc, output int passes);
    logic [15:0] pc = firstPc;
    int badOv = 0;
    passes = 0;
    for (int n = 0; n < 70000; n++) begin
      @(negedge clk);
      fetchValid = 1'b1; fetchPc = pc;
      #1;
      if (pc == endPc) passes++;
      if (pcOvrValid) begin
        if (pcOvr != firstPc) badOv++;
        pc = pcOvr;
      end else if (srRestoreValid) begin
        break;
      end else pc = pc + 16'd1;
    end
    @(negedge clk);
    fetchValid = 1'b0;
    chk("R4 redirect address each pass", badOv, 0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        nChecks++; nFails++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    #1;
    chk("R1 reset state", {loopFlag, pcOvrValid, srRestoreValid, overflow}, 0);
    chk("R1 reset regs", {loopAddr, loopCount}, 0);
    // R7: flag clear, fetch at address equal to LA (0)
    fetchAt(16'h0000, 0, 0, 0, "R7 flag clear no redirect");

    // Count 1 with srIn bit 15 set while the flag is clear (R10)
    startLoop(0, 16'd1, 16'h0020, 16'h0020, 16'h8123);
    chk("R2 flag armed", loopFlag, 1);
    chk("R2 end address loaded", loopAddr, 16'h0020);
    fetchAt(16'h001F, 0, 0, 0, "R7 other address no redirect");
    fetchAt(16'h0020, 0, 0, 1, "R6 count one exits");
    chk("R10 saved status carries flag", srRestore, 16'h0123);
    @(negedge clk); fetchValid = 1'b0;
    chk("R6 flag restored clear", loopFlag, 0);

    // Count 2
    startLoop(0, 16'd2, 16'h0043, 16'h0040, 16'h0000);
    runPasses(16'h0040, 16'h0043, p);
    chk("R4 two passes", p, 2);

    // Short immediate: upper bits cleared
    startLoop(1, 16'hF003, 16'h0055, 16'h0050, 16'h0000);
    chk("R3 short count", loopCount, 16'h0003);
    runPasses(16'h0050, 16'h0055, p);
    chk("R3 short passes", p, 3);

    // Count 0 = 65536, one-instruction body
    startLoop(0, 16'd0, 16'h0070, 16'h0070, 16'h0000);
    runPasses(16'h0070, 16'h0070, p);
    chk("R5 zero count passes", p, 65536);
    chk("R6 stack emptied flag", loopFlag, 0);

    // Nested: outer 0x100..0x10F x3, inner 0x106..0x108 x2
    startLoop(0, 16'd3, 16'h010F, 16'h0100, 16'h0001);
    for (int a = 16'h100; a <= 16'h104; a++) fetchAt(16'(a), 0, 0, 0, "R7 outer body");
    startLoop(0, 16'd2, 16'h0108, 16'h0106, 16'h0002);
    chk("R2 inner state", {loopAddr, loopCount}, {16'h0108, 16'h0002});
    fetchAt(16'h0106, 0, 0, 0, "R7 inner body");
    fetchAt(16'h0107, 0, 0, 0, "R7 inner body");
    fetchAt(16'h0108, 1, 16'h0106, 0, "R4 inner loop back");
    fetchAt(16'h0106, 0, 0, 0, "R7 inner body");
    fetchAt(16'h0107, 0, 0, 0, "R7 inner body");
    fetchAt(16'h0108, 0, 0, 1, "R6 inner exit");
    chk("R10 inner saved status", srRestore, 16'h8002);
    @(negedge clk); fetchValid = 1'b0;
    chk("R8 outer restored", {loopAddr, loopCount}, {16'h010F, 16'h0003});
    chk("R8 outer flag", loopFlag, 1);
    for (int a = 16'h109; a <= 16'h10E; a++) fetchAt(16'(a), 0, 0, 0, "R7 outer body");
    fetchAt(16'h010F, 1, 16'h0100, 0, "R8 outer loop back");
    @(negedge clk); fetchValid = 1'b0;
    runPasses(16'h0100, 16'h010F, p);
    chk("R8 outer remaining passes", p, 2);
    chk("R8 all loops closed", loopFlag, 0);

    // Overflow: 7 starts fill 14 entries, the 8th overflows
    for (int k = 0; k < 7; k++) startLoop(0, 16'd5, 16'(16'h200 + k), 16'h01F0, 16'h0000);
    chk("R9 no overflow at 14", overflow, 0);
    startLoop(0, 16'd5, 16'h0300, 16'h01F0, 16'h0000);
    chk("R9 overflow set", overflow, 1);
    repeat (3) @(negedge clk);
    chk("R9 overflow sticky", overflow, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule